// File: doc/BRIEF.md
# Nine-Bit Serial Display Command Link

This block is the master side of a three-wire serial link to a small display controller that has no separate data/command pin. Each byte goes out as a nine-bit word: a leading flag bit tells the panel whether the remaining eight bits are a command (flag 0) or a parameter or pixel byte (flag 1). Items arrive on a ready/valid input, each tagged with its kind and with an end-of-command marker. The block drives chip select, serial clock and serial data out, and derives all bit timing from the system clock.

A command and all of its parameters share one chip-select frame. Sixteen-bit pixels are split into two data words, high byte first, and run at the full configured serial rate. Command and parameter words run at a capped rate, and register reads use a third, slower rate. When a command code belongs to the set of readable registers, the block sends the command word and then, still inside the same frame, clocks in eight response bits from the serial data input. It returns them as one byte with a single-cycle valid pulse.

Top module: `dbi9_link_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `in_ready` is high and `rd_valid` is low.
- R2: Each word has 9 bits, sent first bit first. The first bit is 0 when `in_kind` is 0 (command) and 1 for any other kind (1 = parameter, 2 = pixel, 3 = treated as parameter). The 8 payload bits follow most significant bit first. For commands and parameters the payload is `in_data[7:0]`.
- R3: Serial data changes only while the clock is low. The clock rises in mid-bit, so the panel samples on the rising edge. The clock is low whenever chip select is high.
- R4: Chip select falls when a frame's first item is accepted. It stays low across all items up to and including the one with `in_last` = 1, then goes high.
- R5: A pixel item (`in_kind` = 2) is sent as two data words: `in_data[15:8]` first, then `in_data[7:0]`, both with flag 1 and with chip select held low.
- R6: Command and parameter words use a clock half-period of ceil(SYS_HZ / (2·min(10 MHz, MAX_HZ))) system cycles.
- R7: Pixel words use a clock half-period of ceil(SYS_HZ / (2·MAX_HZ)) system cycles.
- R8: A read frame uses a clock half-period of ceil(SYS_HZ / (2·min(2 MHz, MAX_HZ/2))) system cycles for its command word and for its response bits.
- R9: A command whose code is one of 0x04, 0x06–0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 or 0xA8 is a read. In the same frame as the command word, the block clocks in 8 further bits, sampling `lcd_sdi` on their rising edges, first bit as the most significant. It then raises chip select and presents the byte on `rd_data` with `rd_valid` high for exactly one cycle.
- R10: Any other command code is a write. It gets no response phase and never raises `rd_valid`. A read frame ends after its response regardless of `in_last`.
- R11: `in_ready` is low while a word is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Item available |
| in_ready | output | 1 | Block can take an item this cycle |
| in_kind | input | 2 | 0 command, 1 parameter, 2 pixel, 3 parameter |
| in_data | input | 16 | Payload; low byte for command and parameter, whole pixel for kind 2 |
| in_last | input | 1 | Item ends its command frame |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_sclk | output | 1 | Serial clock, idles low |
| lcd_sdo | output | 1 | Serial data to the panel |
| lcd_sdi | input | 1 | Serial data from the panel during reads |
| rd_valid | output | 1 | One-cycle pulse with a read result |
| rd_data | output | 8 | Read result byte |

## Verification
The bench watches the serial pins as a panel would. It rebuilds every word from rising-edge samples and checks it together with the frame it fell in and the clock-high width of each bit. A design that put the flag last, or dropped it for pixel bytes, shows up as wrong words. One that sent the low pixel byte first, or released chip select between a command and its parameters, puts bytes in the wrong frame. One that kept the capped rate for pixels, or used the write rate for reads, gives wrong bit widths. The read tests use a readable code and a look-alike write code. A decoder that missed a code, or a response shifted by one bit, shows up either as a missing or extra response phase or as a wrong returned byte.

// File: rtl/dbi9_pkg.sv
// Shared types and timing helpers for the nine-bit serial display link.
// Assumes all rates are given in Hz and the system clock is the fastest.
package dbi9_pkg;

    // Item kinds on the input stream
    localparam logic [1:0] KIND_CMD   = 2'd0;
    localparam logic [1:0] KIND_PARAM = 2'd1;
    localparam logic [1:0] KIND_PIXEL = 2'd2;

    // Caps on serial rates for control traffic and for reads
    localparam longint unsigned CTRL_CAP_HZ = 64'd10_000_000;
    localparam longint unsigned READ_CAP_HZ = 64'd2_000_000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2,
        ST_GAP  = 2'd3
    } link_state_e;

    // Half-period in system cycles for a wanted bit rate, rounded up, at least 1
    function automatic int unsigned half_period(longint unsigned sys_hz,
                                                longint unsigned bit_hz);
        longint unsigned h;
        h = (sys_hz + 2 * bit_hz - 1) / (2 * bit_hz);
        if (h < 1) h = 1;
        return int'(h);
    endfunction

endpackage

// File: rtl/dbi9_read_decode.sv
// Classifies a command code as a register read or a write.
// Assumes the code set is fixed; any code not listed is a write.
module dbi9_read_decode (
    input  logic [7:0] code,
    output logic       is_read
);

    // Match the code against the readable register set
    always_comb begin
        case (code)
            8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
            8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
            8'h56, 8'h5F, 8'hA1, 8'hA8: is_read = 1'b1;
            default:                    is_read = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbi9_serializer.sv
// Shifts one 9-bit word out, or 8 bits in, with a programmable half-period.
// Data changes with the falling clock and input is sampled at the rising clock.
// Assumes start is raised only while idle and that sdi is stable for a half-period
// around each rising clock edge.
module dbi9_serializer #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rx_mode,
    input  logic [8:0]        word,
    input  logic [HALF_W-1:0] half,
    input  logic              sdi,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sdo,
    output logic [7:0]        rx_byte
);

    logic [8:0]        sh_q;
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] reload_q;
    logic [3:0]        nleft_q;
    logic              sclk_q;
    logic              busy_q;
    logic              done_q;
    logic              rx_q;
    logic [7:0]        rxsh_q;

    // Bit timing, shifting and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            reload_q <= '0;
            nleft_q  <= '0;
            sclk_q   <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            rx_q     <= 1'b0;
            rxsh_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                sh_q     <= word;
                reload_q <= half;
                cnt_q    <= half - 1'b1;
                nleft_q  <= rx_mode ? 4'd8 : 4'd9;
                rx_q     <= rx_mode;
                busy_q   <= 1'b1;
                sclk_q   <= 1'b0;
            end else if (busy_q) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    cnt_q <= reload_q - 1'b1;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        if (rx_q) rxsh_q <= {rxsh_q[6:0], sdi};
                    end else begin
                        sclk_q  <= 1'b0;
                        sh_q    <= {sh_q[7:0], 1'b0};
                        nleft_q <= nleft_q - 1'b1;
                        if (nleft_q == 4'd1) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Output drive: data only while transmitting
    assign sdo     = busy_q && !rx_q && sh_q[8];
    assign sclk    = sclk_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_byte = rxsh_q;

    // R3: serial data holds while the clock is high
    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q |=> (!sclk_q || $stable(sdo)));

    // R3: clock is low whenever no word is in flight
    p_sclk_idle_ser_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);

    // R11: a start never lands on a busy shifter
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

endmodule

// File: rtl/dbi9_link_master.sv
// Master for a three-wire display link that carries the data/command flag as a
// leading ninth bit. Takes command, parameter and pixel items from a ready/valid
// input, frames them under chip select, and performs single-byte register reads.
// Assumes the system clock is at least twice the fastest serial rate.
module dbi9_link_master #(
    parameter longint unsigned SYS_HZ = 64'd100_000_000,
    parameter longint unsigned MAX_HZ = 64'd25_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [1:0]  in_kind,
    input  logic [15:0] in_data,
    input  logic        in_last,
    output logic        lcd_cs_n,
    output logic        lcd_sclk,
    output logic        lcd_sdo,
    input  logic        lcd_sdi,
    output logic        rd_valid,
    output logic [7:0]  rd_data
);
    import dbi9_pkg::*;

    localparam longint unsigned CTRL_HZ = (MAX_HZ < CTRL_CAP_HZ) ? MAX_HZ : CTRL_CAP_HZ;
    localparam longint unsigned RD_HZ   = ((MAX_HZ / 2) < READ_CAP_HZ) ? (MAX_HZ / 2) : READ_CAP_HZ;
    localparam int unsigned HALF_CTRL = half_period(SYS_HZ, CTRL_HZ);
    localparam int unsigned HALF_BULK = half_period(SYS_HZ, MAX_HZ);
    localparam int unsigned HALF_RD   = half_period(SYS_HZ, RD_HZ);
    localparam int unsigned HALF_MAX  = (HALF_RD > HALF_CTRL) ? HALF_RD : HALF_CTRL;
    localparam int HALF_W = $clog2(HALF_MAX + 1);

    link_state_e       st_q;
    logic              cs_n_q;
    logic              rdf_q;
    logic              last_q;
    logic              pix_pend_q;
    logic [7:0]        pix_lo_q;
    logic              rd_valid_q;
    logic [7:0]        rd_data_q;

    logic              accept;
    logic              code_is_read;
    logic              new_read;
    logic              ser_start;
    logic              ser_rx;
    logic [8:0]        ser_word;
    logic [HALF_W-1:0] ser_half;
    logic              ser_busy;
    logic              ser_done;
    logic [7:0]        ser_rx_byte;

    dbi9_read_decode u_dec (
        .code    (in_data[7:0]),
        .is_read (code_is_read)
    );

    assign in_ready = (st_q == ST_IDLE) || (st_q == ST_GAP);
    assign accept   = in_valid && in_ready;
    assign new_read = (in_kind == KIND_CMD) && code_is_read;

    // Pick the next word, its rate and its direction
    always_comb begin
        ser_start = 1'b0;
        ser_rx    = 1'b0;
        ser_word  = '0;
        ser_half  = HALF_W'(HALF_CTRL);
        if (accept) begin
            ser_start = 1'b1;
            ser_word  = {in_kind != KIND_CMD,
                         (in_kind == KIND_PIXEL) ? in_data[15:8] : in_data[7:0]};
            if (in_kind == KIND_PIXEL) ser_half = HALF_W'(HALF_BULK);
            else if (new_read)         ser_half = HALF_W'(HALF_RD);
        end else if (ser_done && pix_pend_q) begin
            ser_start = 1'b1;
            ser_word  = {1'b1, pix_lo_q};
            ser_half  = HALF_W'(HALF_BULK);
        end else if (ser_done && (st_q == ST_SEND) && rdf_q) begin
            ser_start = 1'b1;
            ser_rx    = 1'b1;
            ser_half  = HALF_W'(HALF_RD);
        end
    end

    dbi9_serializer #(.HALF_W(HALF_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ser_start),
        .rx_mode (ser_rx),
        .word    (ser_word),
        .half    (ser_half),
        .sdi     (lcd_sdi),
        .busy    (ser_busy),
        .done    (ser_done),
        .sclk    (lcd_sclk),
        .sdo     (lcd_sdo),
        .rx_byte (ser_rx_byte)
    );

    // Frame sequencing: chip select, pixel split, read phase, result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cs_n_q     <= 1'b1;
            rdf_q      <= 1'b0;
            last_q     <= 1'b0;
            pix_pend_q <= 1'b0;
            pix_lo_q   <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            case (st_q)
                ST_IDLE, ST_GAP: begin
                    if (accept) begin
                        cs_n_q     <= 1'b0;
                        st_q       <= ST_SEND;
                        rdf_q      <= new_read;
                        last_q     <= in_last;
                        pix_pend_q <= (in_kind == KIND_PIXEL);
                        pix_lo_q   <= in_data[7:0];
                    end
                end
                ST_SEND: begin
                    if (ser_done) begin
                        if (pix_pend_q) begin
                            pix_pend_q <= 1'b0;
                        end else if (rdf_q) begin
                            st_q <= ST_RECV;
                        end else if (last_q) begin
                            cs_n_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            st_q <= ST_GAP;
                        end
                    end
                end
                ST_RECV: begin
                    if (ser_done) begin
                        rd_data_q  <= ser_rx_byte;
                        rd_valid_q <= 1'b1;
                        rdf_q      <= 1'b0;
                        cs_n_q     <= 1'b1;
                        st_q       <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign lcd_cs_n = cs_n_q;
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    // R3: no clock activity outside a frame
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cs_n |-> !lcd_sclk);

    // R4: chip select stays low while waiting for the rest of a command
    p_gap_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP) |-> !lcd_cs_n);

    // R11: no new item is taken while a word is shifting
    p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ser_busy |-> !in_ready);

    // R9: the read result is a single-cycle pulse
    p_rdvalid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R10: a result only ever follows a read frame
    p_rdvalid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rdf_q));

endmodule

// File: tb/tb_dbi9_link_master.sv
// Self-checking bench: drives items, observes the serial pins like a panel would.
module tb_dbi9_link_master;

    localparam int CLK_PERIOD = 10;
    localparam longint unsigned SYS_HZ = 64'd100_000_000;
    localparam longint unsigned MAX_HZ = 64'd25_000_000;
    // Expected half-periods, from R6/R7/R8: 10 MHz cap, full rate, 2 MHz cap
    localparam int H_CTRL = 5;
    localparam int H_BULK = 2;
    localparam int H_RD   = 25;

    localparam int NV = 11;
    // {kind[1:0], data[15:0], last}
    localparam logic [18:0] VEC [0:NV-1] = '{
        {2'd0, 16'h002A, 1'b0},
        {2'd1, 16'h0000, 1'b0},
        {2'd1, 16'h0012, 1'b0},
        {2'd3, 16'h0000, 1'b0},
        {2'd1, 16'h00EF, 1'b1},
        {2'd0, 16'h002C, 1'b0},
        {2'd2, 16'hF81F, 1'b0},
        {2'd2, 16'h07E0, 1'b1},
        {2'd0, 16'h0011, 1'b1},
        {2'd0, 16'h0029, 1'b0},
        {2'd1, 16'h00A5, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = '0;
    logic [15:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        lcd_cs_n, lcd_sclk, lcd_sdo;
    logic        lcd_sdi = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;

    dbi9_link_master #(.SYS_HZ(SYS_HZ), .MAX_HZ(MAX_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_data(in_data), .in_last(in_last),
        .lcd_cs_n(lcd_cs_n), .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo),
        .lcd_sdi(lcd_sdi), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Panel-side monitor state
    logic bit_v  [0:1023];
    int   bit_fr [0:1023];
    int   bit_hw [0:1023];
    int   nb = 0;
    int   frames = 0;
    int   hcnt = 0;
    int   idle_clk_err = 0;
    int   hold_err = 0;
    int   cycle = 0;
    int   fall_cnt = 0;
    logic [7:0] resp = 8'h00;

    // Sample data on each rising clock, tagged with the frame number
    always @(posedge lcd_sclk) begin
        if (nb < 1024) begin
            bit_v[nb]  = lcd_sdo;
            bit_fr[nb] = frames;
        end
        nb = nb + 1;
    end

    always @(posedge lcd_cs_n) frames = frames + 1;

    // Panel response: drive each read bit after a falling clock
    always @(negedge lcd_sclk or posedge lcd_cs_n) begin
        if (lcd_cs_n) begin
            fall_cnt = 0;
            lcd_sdi  = 1'b0;
        end else begin
            fall_cnt = fall_cnt + 1;
            if (fall_cnt >= 9 && fall_cnt < 17) lcd_sdi = resp[16 - fall_cnt];
            else lcd_sdi = 1'b0;
        end
    end

    // Clock-high width, idle-clock and data-hold monitoring, watchdog
    always @(posedge clk) begin
        cycle = cycle + 1;
        if (lcd_cs_n && lcd_sclk) idle_clk_err = idle_clk_err + 1;
        if (lcd_sclk && nb > 0 && nb <= 1024 && lcd_sdo !== bit_v[nb-1]) hold_err = hold_err + 1;
        if (lcd_sclk) hcnt = hcnt + 1;
        else if (hcnt != 0) begin
            if (nb > 0 && nb <= 1024) bit_hw[nb-1] = hcnt;
            hcnt = 0;
        end
        if (cycle == 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cycle);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [15:0] d, input logic l);
        @(negedge clk);
        in_valid = 1'b1;
        in_kind  = k;
        in_data  = d;
        in_last  = l;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (n < 20) begin
            @(negedge clk);
            if (lcd_cs_n && in_ready) n = n + 1;
            else n = 0;
        end
    endtask

    function automatic int word_at(input int idx);
        int w;
        w = 0;
        for (int b = 0; b < 9; b++) w = (w << 1) | int'(bit_v[idx + b]);
        return w;
    endfunction

    task automatic do_read(input logic [7:0] code, input logic [7:0] r, input string tag);
        int base, fb, n;
        bit seen;
        logic [7:0] got;
        resp = r;
        base = nb;
        fb = frames;
        seen = 1'b0;
        got = '0;
        send(2'd0, {8'h00, code}, 1'b0);
        n = 0;
        while (!seen && n < 3000) begin
            @(negedge clk);
            if (rd_valid) begin seen = 1'b1; got = rd_data; end
            n = n + 1;
        end
        check(seen, {tag, " R9 read result pulse"}, int'(seen), 1);
        check(got == r, {tag, " R9 read data"}, int'(got), int'(r));
        @(negedge clk);
        check(!rd_valid, {tag, " R9 single-cycle valid"}, int'(rd_valid), 0);
        wait_idle();
        check(nb - base == 17, {tag, " R9 command plus 8 response clocks"}, nb - base, 17);
        check(word_at(base) == int'({1'b0, code}), {tag, " R2 read command word"}, word_at(base), int'({1'b0, code}));
        check(bit_hw[base] == H_RD && bit_hw[base + 16] == H_RD, {tag, " R8 read half-period"}, bit_hw[base + 16], H_RD);
        check(bit_fr[base] == fb && bit_fr[base + 16] == fb, {tag, " R9 same frame"}, bit_fr[base + 16], fb);
    endtask

    int ew [0:31];
    int eh [0:31];
    int ef [0:31];

    initial begin
        int nw, base, fb, fi, n;
        bit seen;
        logic [1:0] k;
        logic [15:0] d;
        logic l;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(lcd_cs_n == 1'b1, "R1 cs high after reset", int'(lcd_cs_n), 1);
        check(lcd_sclk == 1'b0, "R1 clock low after reset", int'(lcd_sclk), 0);
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(rd_valid == 1'b0, "R1 no result after reset", int'(rd_valid), 0);

        // Table walk: writes, parameters, pixels, frames (R2 R4 R5 R6 R7)
        base = nb;
        fb = frames;
        nw = 0;
        fi = 0;
        for (int i = 0; i < NV; i++) begin
            {k, d, l} = VEC[i];
            send(k, d, l);
            if (i == 0) check(!in_ready, "R11 ready low while shifting", int'(in_ready), 0);
            if (k == 2'd2) begin
                ew[nw] = int'({1'b1, d[15:8]}); eh[nw] = H_BULK; ef[nw] = fb + fi; nw++;
                ew[nw] = int'({1'b1, d[7:0]});  eh[nw] = H_BULK; ef[nw] = fb + fi; nw++;
            end else begin
                ew[nw] = int'({k != 2'd0, d[7:0]}); eh[nw] = H_CTRL; ef[nw] = fb + fi; nw++;
            end
            if (l) fi++;
        end
        wait_idle();
        check(nb - base == nw * 9, "R2 total bits sent", nb - base, nw * 9);
        for (int w = 0; w < nw; w++) begin
            check(word_at(base + 9 * w) == ew[w], "R2 R5 word value", word_at(base + 9 * w), ew[w]);
            check(bit_hw[base + 9 * w + 8] == eh[w],
                  (eh[w] == H_BULK) ? "R7 pixel half-period" : "R6 control half-period",
                  bit_hw[base + 9 * w + 8], eh[w]);
            check(bit_fr[base + 9 * w] == ef[w] && bit_fr[base + 9 * w + 8] == ef[w],
                  "R4 word in its command frame", bit_fr[base + 9 * w + 8], ef[w]);
        end
        check(frames - fb == fi, "R4 frames released", frames - fb, fi);

        // Reads of listed codes
        do_read(8'h0A, 8'h9C, "power");
        do_read(8'h04, 8'h5A, "ident");
        do_read(8'h0C, 8'h81, "format");

        // R10: unlisted command is a plain write
        base = nb;
        resp = 8'hFF;
        seen = 1'b0;
        send(2'd0, 16'h0028, 1'b1);
        n = 0;
        while (n < 2000) begin
            @(negedge clk);
            if (rd_valid) seen = 1'b1;
            n = n + 1;
        end
        wait_idle();
        check(!seen, "R10 no result for write code", int'(seen), 0);
        check(nb - base == 9, "R10 no response phase", nb - base, 9);
        check(bit_hw[base] == H_CTRL, "R10 R6 write code at control rate", bit_hw[base], H_CTRL);

        // R3: data held while clock high, clock low outside frames
        check(hold_err == 0, "R3 data stable while clock high", hold_err, 0);
        check(idle_clk_err == 0, "R3 clock low while deselected", idle_clk_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule